// File: doc/BRIEF.md
# I2C Master Address and Transmit Sequencer

This block runs the opening of an I2C master transfer. On a start request it puts a START on the bus, then the address bytes for a 7-bit or a 10-bit slave address, and it checks the acknowledge after every byte. In transmit direction it then sends data bytes from a one-byte holding register. It holds SCL low whenever the next byte has not been supplied. In receive direction it holds SCL low once the address phase ends. A stop request ends the transfer with a STOP condition.

Both bus lines are open drain. `scl_o` and `sda_o` are release enables, where 1 lets the line float high, and `sda_i` is the resolved SDA level. Every bit is built from four quarter-periods of a fixed clock divider. A NACK on any byte ends the byte flow and sets an error flag. The bus then stays parked until a stop request arrives.

Top module: `i2c_addr_seq`

## Requirements
- R1: After reset, `scl_o`=1, `sda_o`=1, `busy`=0, `stalled`=0, `tx_mode`=0 and `nack_err`=0.
- R2: In 7-bit mode (`addr_ten`=0), a START is followed by exactly one address byte, `{slv_addr[6:0], rd_req}`, with the direction in bit 0.
- R3: In 10-bit mode with `rd_req`=0, the START is followed by the header `{5'b11110, slv_addr[9:8], 1'b0}` and then `slv_addr[7:0]`.
- R4: In 10-bit mode with `rd_req`=1, the bytes of R3 are followed by a repeated START and the header `{5'b11110, slv_addr[9:8], 1'b1}`.
- R5: `tx_mode` changes only when a byte that carries a direction bit is acknowledged. It becomes the inverse of that bit, so after a complete address phase it equals `!rd_req`.
- R6: In transmit direction, no data byte leaves until `hold_wr` has loaded the holding register. While the register is empty, SCL is held low and `stalled`=1.
- R7: Data bytes go out MSB first, and each loaded byte is sent exactly once, in load order. A byte loaded while the previous one is on the bus follows it with no stall. A `hold_wr` in the same cycle that the held byte is taken is kept as the next byte.
- R8: A NACK on any address or data byte sets `nack_err` and no further byte is sent. `stalled`=1 until `stop_req`. `nack_err` clears when the next transfer starts.
- R9: `stop_req` in a waiting state produces a STOP, after which `busy` falls. If a loaded byte is pending in the same cycle, the stop wins, and that byte stays held and is the first data byte of the next transmit transfer.
- R10: SDA changes while SCL is high only for START, repeated START and STOP. Every data and address bit is stable across its SCL high time.
- R11: In receive direction, after the address phase SCL is held low with `stalled`=1 until `stop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| start_req | input | 1 | Pulse: begin a transfer with the address inputs (taken only when idle) |
| addr_ten | input | 1 | 1 selects 10-bit addressing |
| rd_req | input | 1 | Direction request, 1 means read |
| slv_addr | input | 10 | Slave address; bits [6:0] are used in 7-bit mode |
| hold_wr | input | 1 | Pulse: load `hold_data` into the holding register |
| hold_data | input | 8 | Next data byte |
| stop_req | input | 1 | Pulse: end the transfer with a STOP while waiting |
| sda_i | input | 1 | Resolved SDA line level |
| scl_o | output | 1 | SCL release (0 pulls low) |
| sda_o | output | 1 | SDA release (0 pulls low) |
| busy | output | 1 | A transfer is in progress |
| stalled | output | 1 | SCL held low, waiting for a byte or a stop |
| tx_mode | output | 1 | 1 transmitter, 0 receiver |
| nack_err | output | 1 | Last transfer ended on a NACK |

## Verification
Two functions can meet in the same clock edge. Taking the pending held byte can coincide with a new `hold_wr`, and it can also coincide with `stop_req`. The bench provokes the first case by driving `hold_wr` on two consecutive cycles just after the address phase. The slave model must then see both bytes in order, and nothing may be lost. It provokes the second case by raising `stop_req` in the cycle right after a load, so that the STOP must come straight after the address and the unsent byte must open the next transfer.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {CMD_START, CMD_STOP, CMD_BYTE} eng_cmd_t;
  typedef enum logic [1:0] {ITEM_START, ITEM_BYTE, ITEM_END} item_kind_t;

  typedef struct packed {
    item_kind_t kind;
    logic       has_dir;
    logic [7:0] value;
  } seq_item_t;

  // Line levels {scl, sda} for one quarter of a bit slot.
  function automatic logic [1:0] phase_lines(eng_cmd_t c, logic [1:0] ph, logic b);
    logic [1:0] r;
    case (c)
      CMD_START: case (ph)
                   2'd0: r = 2'b01;
                   2'd1: r = 2'b11;
                   2'd2: r = 2'b10;
                   default: r = 2'b00;
                 endcase
      CMD_STOP:  case (ph)
                   2'd0: r = 2'b00;
                   2'd1: r = 2'b10;
                   default: r = 2'b11;
                 endcase
      default:   r = {(ph == 2'd1 || ph == 2'd2), b};
    endcase
    return r;
  endfunction

  function automatic logic [7:0] ten_header(logic [9:0] a, logic dir);
    return {5'b11110, a[9:8], dir};
  endfunction

  // Address phase as an indexed list of bus items.
  function automatic seq_item_t addr_item(logic [2:0] step, logic ten, logic rd, logic [9:0] a);
    seq_item_t it;
    it = '{kind: ITEM_END, has_dir: 1'b0, value: 8'h00};
    if (step == 3'd0) it.kind = ITEM_START;
    else if (!ten) begin
      if (step == 3'd1) it = '{kind: ITEM_BYTE, has_dir: 1'b1, value: {a[6:0], rd}};
    end else begin
      case (step)
        3'd1: it = '{kind: ITEM_BYTE, has_dir: 1'b1, value: ten_header(a, 1'b0)};
        3'd2: it = '{kind: ITEM_BYTE, has_dir: 1'b0, value: a[7:0]};
        3'd3: if (rd) it.kind = ITEM_START;
        3'd4: if (rd) it = '{kind: ITEM_BYTE, has_dir: 1'b1, value: ten_header(a, 1'b1)};
        default: ;
      endcase
    end
    return it;
  endfunction

endpackage

// File: rtl/i2c_qtick.sv
module i2c_qtick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2c_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       go,
  input  eng_cmd_t   cmd,
  input  logic [7:0] byte_in,
  input  logic       sda_i,
  output logic       busy,
  output logic       done,
  output logic       ack_ok,
  output logic       scl_o,
  output logic       sda_o,
  output eng_cmd_t   cur_cmd
);
  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [1:0] ph;
  logic [3:0] bitn;
  logic [7:0] sh;
  logic       last_slot, cur_val, nxt_val;

  assign last_slot = (cur_cmd == CMD_BYTE) ? (bitn == ACK_SLOT) : 1'b1;
  assign cur_val   = (bitn == ACK_SLOT) ? 1'b1 : sh[7];
  assign nxt_val   = (bitn == 4'd7) ? 1'b1 : sh[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      ack_ok  <= 1'b0;
      cur_cmd <= CMD_STOP;
      ph      <= '0;
      bitn    <= '0;
      sh      <= '0;
      scl_o   <= 1'b1;
      sda_o   <= 1'b1;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy           <= 1'b1;
        cur_cmd        <= cmd;
        ph             <= 2'd0;
        bitn           <= '0;
        sh             <= byte_in;
        {scl_o, sda_o} <= phase_lines(cmd, 2'd0, byte_in[7]);
      end else if (busy && tick) begin
        if (cur_cmd == CMD_BYTE && bitn == ACK_SLOT && ph == 2'd2) ack_ok <= !sda_i;
        if (ph == 2'd3) begin
          if (last_slot) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bitn           <= bitn + 4'd1;
            sh             <= {sh[6:0], 1'b0};
            ph             <= 2'd0;
            {scl_o, sda_o} <= phase_lines(cur_cmd, 2'd0, nxt_val);
          end
        end else begin
          ph             <= ph + 2'd1;
          {scl_o, sda_o} <= phase_lines(cur_cmd, ph + 2'd1, cur_val);
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_seq.sv
module i2c_addr_seq
  import i2c_seq_pkg::*;
#(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       addr_ten,
  input  logic       rd_req,
  input  logic [9:0] slv_addr,
  input  logic       hold_wr,
  input  logic [7:0] hold_data,
  input  logic       stop_req,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_o,
  output logic       busy,
  output logic       stalled,
  output logic       tx_mode,
  output logic       nack_err
);
  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_AWAIT, S_TXWAIT, S_TXBUSY, S_RXHOLD, S_ERRHOLD, S_STOPW
  } st_t;

  st_t        st;
  logic [2:0] step;
  logic [9:0] a_q;
  logic       ten_q, rd_q;
  logic [7:0] hold_q;
  logic       hold_full;
  seq_item_t  item;

  logic       qtick, eng_go, eng_busy, eng_done, eng_ack;
  eng_cmd_t   eng_cmd, eng_cur;
  logic [7:0] eng_byte;
  logic       in_txwait, take_hold, nack_now;

  assign item      = addr_item(step, ten_q, rd_q, a_q);
  assign in_txwait = (st == S_TXWAIT);
  assign take_hold = in_txwait && !stop_req && hold_full;
  assign nack_now  = eng_done && (eng_cur == CMD_BYTE) && !eng_ack;

  always_comb begin
    eng_go   = 1'b0;
    eng_cmd  = CMD_BYTE;
    eng_byte = item.value;
    case (st)
      S_ISSUE: if (item.kind != ITEM_END && !eng_busy) begin
        eng_go  = 1'b1;
        eng_cmd = (item.kind == ITEM_START) ? CMD_START : CMD_BYTE;
      end
      S_TXWAIT: if (stop_req) begin
        eng_go  = 1'b1;
        eng_cmd = CMD_STOP;
      end else if (hold_full) begin
        eng_go   = 1'b1;
        eng_byte = hold_q;
      end
      S_RXHOLD, S_ERRHOLD: if (stop_req) begin
        eng_go  = 1'b1;
        eng_cmd = CMD_STOP;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      step      <= '0;
      a_q       <= '0;
      ten_q     <= 1'b0;
      rd_q      <= 1'b0;
      hold_q    <= '0;
      hold_full <= 1'b0;
      tx_mode   <= 1'b0;
      nack_err  <= 1'b0;
    end else begin
      if (hold_wr) begin
        hold_q    <= hold_data;
        hold_full <= 1'b1;
      end else if (take_hold) begin
        hold_full <= 1'b0;
      end
      case (st)
        S_IDLE: if (start_req) begin
          a_q      <= slv_addr;
          ten_q    <= addr_ten;
          rd_q     <= rd_req;
          step     <= '0;
          nack_err <= 1'b0;
          st       <= S_ISSUE;
        end
        S_ISSUE:
          if (item.kind == ITEM_END) st <= rd_q ? S_RXHOLD : S_TXWAIT;
          else if (eng_go) st <= S_AWAIT;
        S_AWAIT: if (eng_done) begin
          if (nack_now) begin
            nack_err <= 1'b1;
            st       <= S_ERRHOLD;
          end else begin
            if (item.kind == ITEM_BYTE && item.has_dir) tx_mode <= !item.value[0];
            step <= step + 3'd1;
            st   <= S_ISSUE;
          end
        end
        S_TXWAIT: if (eng_go) st <= stop_req ? S_STOPW : S_TXBUSY;
        S_TXBUSY: if (eng_done) begin
          if (nack_now) begin
            nack_err <= 1'b1;
            st       <= S_ERRHOLD;
          end else st <= S_TXWAIT;
        end
        S_RXHOLD, S_ERRHOLD: if (stop_req) st <= S_STOPW;
        S_STOPW: if (eng_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign stalled = (in_txwait && !hold_full) || (st == S_RXHOLD) || (st == S_ERRHOLD);

  i2c_qtick #(.QDIV(QDIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (qtick)
  );

  i2c_bit_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (qtick),
    .go      (eng_go),
    .cmd     (eng_cmd),
    .byte_in (eng_byte),
    .sda_i   (sda_i),
    .busy    (eng_busy),
    .done    (eng_done),
    .ack_ok  (eng_ack),
    .scl_o   (scl_o),
    .sda_o   (sda_o),
    .cur_cmd (eng_cur)
  );
endmodule

// File: rtl/i2c_addr_seq_chk.sv
module i2c_addr_seq_chk
  import i2c_seq_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     scl_o,
  input logic     sda_o,
  input logic     stop_req,
  input logic     stalled,
  input logic     nack_err,
  input logic     eng_busy,
  input logic     eng_done,
  input logic     eng_ack,
  input eng_cmd_t eng_cmd_now,
  input logic     in_txwait,
  input logic     hold_full
);
  // R10
  sda_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |-> (eng_cmd_now != CMD_BYTE));

  // R8
  nack_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && eng_cmd_now == CMD_BYTE && !eng_ack) |=> (nack_err && stalled));

  // R9
  stop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_txwait && stop_req) |=> (eng_busy && eng_cmd_now == CMD_STOP));

  // R6
  stall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |-> !scl_o);

  // R6
  no_early_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_txwait && !hold_full && !stop_req) |=> !eng_busy);
endmodule

bind i2c_addr_seq i2c_addr_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .scl_o       (scl_o),
  .sda_o       (sda_o),
  .stop_req    (stop_req),
  .stalled     (stalled),
  .nack_err    (nack_err),
  .eng_busy    (eng_busy),
  .eng_done    (eng_done),
  .eng_ack     (eng_ack),
  .eng_cmd_now (eng_cur),
  .in_txwait   (in_txwait),
  .hold_full   (hold_full)
);

// File: tb/i2c_addr_seq_tb.sv
module i2c_addr_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_req = 1'b0, addr_ten = 1'b0, rd_req = 1'b0;
  logic [9:0] slv_addr = '0;
  logic       hold_wr = 1'b0, stop_req = 1'b0;
  logic [7:0] hold_data = '0;
  logic       sda_i, scl_o, sda_o, busy, stalled, tx_mode, nack_err;
  logic       sda_s = 1'b1;

  int errors = 0, checks = 0;
  logic [9:0] lg [0:63];
  int lg_n = 0;
  logic [9:0] ex [0:63];
  int ex_n = 0;
  int nk_sel = -1;
  logic [7:0] dq [0:3];
  logic carry_v = 1'b0;
  logic [7:0] carry_b = '0;

  localparam logic [9:0] EV_START = 10'h100;
  localparam logic [9:0] EV_STOP  = 10'h200;

  assign sda_i = sda_o & sda_s;

  always #5 clk = ~clk;

  i2c_addr_seq #(.QDIV(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .addr_ten(addr_ten),
    .rd_req(rd_req), .slv_addr(slv_addr), .hold_wr(hold_wr), .hold_data(hold_data),
    .stop_req(stop_req), .sda_i(sda_i), .scl_o(scl_o), .sda_o(sda_o), .busy(busy),
    .stalled(stalled), .tx_mode(tx_mode), .nack_err(nack_err)
  );

  function automatic logic [7:0] hdr10(logic [9:0] a, logic d);
    return {5'b11110, a[9:8], d};
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] v);
    if (ex_n < 64) ex[ex_n] = v;
    ex_n++;
  endtask

  // Slave model: logs START/STOP/bytes, drives ACK or NACK.
  initial begin
    logic ps, pd, s, d;
    int bitc, bidx;
    logic [7:0] shv;
    ps = 1'b1; pd = 1'b1; bitc = 0; bidx = 0; shv = '0;
    forever begin
      @(negedge clk);
      s = scl_o;
      d = sda_o & sda_s;
      if (ps && s && pd && !d) begin
        if (lg_n < 64) lg[lg_n] = EV_START;
        lg_n++; bitc = 0;
      end else if (ps && s && !pd && d) begin
        if (lg_n < 64) lg[lg_n] = EV_STOP;
        lg_n++; bitc = 0; bidx = 0;
      end else if (!ps && s) begin
        if (bitc < 8) begin shv = {shv[6:0], d}; bitc++; end
        else if (bitc == 8) bitc = 9;
      end else if (ps && !s) begin
        if (bitc == 8) begin
          if (lg_n < 64) lg[lg_n] = {2'b00, shv};
          lg_n++;
          sda_s = (bidx == nk_sel) ? 1'b1 : 1'b0;
          bidx++;
        end else if (bitc == 9) begin
          sda_s = 1'b1; bitc = 0;
        end
      end
      ps = s; pd = d;
    end
  end

  task automatic wait_stalled();
    @(negedge clk);
    while (!stalled) @(negedge clk);
  endtask

  task automatic pulse_hold(input logic [7:0] v);
    hold_data = v; hold_wr = 1'b1;
    @(negedge clk);
    hold_wr = 1'b0;
  endtask

  // mode 0: one byte at a time; 1: two loads on consecutive cycles;
  // 2: load then stop next cycle; 3: second load while first is on the bus
  task automatic run_xfer(input logic ten, input logic [9:0] a, input logic rd,
                          input int nd, input int nk, input int mode);
    logic [7:0] ab [0:2];
    int nab, bi, nsent;
    logic stopped, addr_nacked, use_carry;
    ex_n = 0; bi = 0; stopped = 1'b0;
    if (!ten) begin ab[0] = {a[6:0], rd}; nab = 1; end
    else begin
      ab[0] = hdr10(a, 1'b0); ab[1] = a[7:0]; nab = 2;
      if (rd) begin ab[2] = hdr10(a, 1'b1); nab = 3; end
    end
    push(EV_START);
    for (int k = 0; k < nab; k++) begin
      if (k == 2) push(EV_START);
      push({2'b00, ab[k]});
      if (bi == nk) stopped = 1'b1;
      bi++;
      if (stopped) break;
    end
    addr_nacked = stopped;
    use_carry = carry_v && !rd && !addr_nacked;
    nsent = (mode == 2) ? 0 : nd;
    if (!stopped && !rd) begin
      if (use_carry) begin
        push({2'b00, carry_b});
        if (bi == nk) stopped = 1'b1;
        bi++;
      end
      for (int j = 0; j < nsent && !stopped; j++) begin
        push({2'b00, dq[j]});
        if (bi == nk) stopped = 1'b1;
        bi++;
      end
    end
    push(EV_STOP);

    @(negedge clk);
    lg_n = 0; nk_sel = nk;
    addr_ten = ten; slv_addr = a; rd_req = rd; start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    // R8: error flag cleared by a new start
    chk(nack_err == 1'b0, "R8 clear on start", nack_err, 0);
    wait_stalled();
    if (use_carry) carry_v = 1'b0;
    if (!addr_nacked)
      // R5: mode follows the sent direction bit
      chk(tx_mode == !rd, "R5 tx_mode", tx_mode, !rd);
    if (!rd && !addr_nacked && !nack_err) begin
      if (mode == 0) begin
        for (int j = 0; j < nd; j++) begin
          if (nack_err) break;
          pulse_hold(dq[j]);
          wait_stalled();
        end
      end else if (mode == 1) begin
        hold_data = dq[0]; hold_wr = 1'b1;
        @(negedge clk);
        hold_data = dq[1];
        @(negedge clk);
        hold_wr = 1'b0;
        wait_stalled();
      end else if (mode == 3) begin
        pulse_hold(dq[0]);
        repeat (10) @(negedge clk);
        chk(stalled == 1'b0, "R7 no stall while byte in flight", stalled, 0);
        pulse_hold(dq[1]);
        wait_stalled();
      end
    end
    for (int c = 0; c < 4; c++) begin
      // R6 (transmit) and R11 (receive): SCL parked low while stalled
      if (rd && !addr_nacked) chk(!scl_o && stalled, "R11 hold low", scl_o, 0);
      else chk(!scl_o && stalled, "R6 hold low", scl_o, 0);
      @(negedge clk);
    end
    chk(nack_err == stopped, "R8 nack_err", nack_err, stopped);
    if (mode == 2 && !rd && !addr_nacked) begin
      hold_data = dq[0]; hold_wr = 1'b1;
      @(negedge clk);
      hold_wr = 1'b0; stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
      carry_v = 1'b1; carry_b = dq[0];
    end else begin
      stop_req = 1'b1;
      @(negedge clk);
      stop_req = 1'b0;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    // R9: STOP ends the transfer
    chk(busy == 1'b0 && scl_o && sda_o, "R9 bus idle after stop", {busy, scl_o, sda_o}, 3'b011);
    // R2 R3 R4 R7 R10: bus event sequence as seen by the slave
    chk(lg_n == ex_n, "R2/R3/R4/R7/R10 event count", lg_n, ex_n);
    for (int k = 0; k < ex_n && k < lg_n && k < 64; k++)
      chk(lg[k] == ex[k], "R2/R3/R4/R7/R10 event", lg[k], ex[k]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    // R1: reset values
    chk({scl_o, sda_o} == 2'b11, "R1 lines released", {scl_o, sda_o}, 3);
    chk({busy, stalled, tx_mode, nack_err} == 4'b0000, "R1 flags", {busy, stalled, tx_mode, nack_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({scl_o, sda_o, busy} == 3'b110, "R1 idle after reset", {scl_o, sda_o, busy}, 6);

    dq[0] = 8'hA5; dq[1] = 8'h3C; dq[2] = 8'hFF; dq[3] = 8'h00;
    run_xfer(1'b0, 10'h05A, 1'b0, 2, -1, 0);   // R2 R7
    run_xfer(1'b0, 10'h071, 1'b1, 0, -1, 0);   // R2 R11
    run_xfer(1'b1, 10'h2C3, 1'b0, 1, -1, 0);   // R3
    run_xfer(1'b1, 10'h1E7, 1'b1, 0, -1, 0);   // R4 R5
    run_xfer(1'b0, 10'h011, 1'b0, 2, -1, 1);   // R7 same-cycle load
    run_xfer(1'b0, 10'h022, 1'b0, 2, -1, 3);   // R7 load during byte
    run_xfer(1'b0, 10'h033, 1'b0, 2, 0, 0);    // R8 address NACK
    run_xfer(1'b1, 10'h3FF, 1'b0, 3, 3, 0);    // R8 data NACK
    run_xfer(1'b1, 10'h100, 1'b1, 0, 2, 0);    // R8 NACK on read header
    dq[0] = 8'h96;
    run_xfer(1'b0, 10'h044, 1'b0, 1, -1, 2);   // R9 stop beats pending byte
    dq[0] = 8'h81;
    run_xfer(1'b0, 10'h045, 1'b0, 1, -1, 0);   // R9 held byte opens next transfer

    for (int t = 0; t < 20; t++) begin
      logic ten, rd;
      logic [9:0] a;
      int nd, nk, tot;
      ten = 1'($urandom);
      rd  = 1'($urandom);
      a   = 10'($urandom);
      nd  = rd ? 0 : int'($urandom % 4);
      for (int j = 0; j < 4; j++) dq[j] = 8'($urandom);
      tot = (ten ? (rd ? 3 : 2) : 1) + nd;
      nk  = (($urandom % 5) == 0) ? int'($urandom % tot) : -1;
      run_xfer(ten, a, rd, nd, nk, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule